// File: doc/BRIEF.md
# Command-Driven Quad SPI Word Engine

This block is a half-duplex serial flash engine that a host drives one word at a time. The host first loads a data register. It then writes a command word that selects a chip select, a word length, a frame length and an operation. The engine sends one word out on a single line, or receives one word on one, two or four lines. After each word it raises a completion flag and, if the command asked for it, an interrupt. Read results are placed back in the data register.

Each chip select has its own configuration byte, which sets clock polarity, clock phase and chip-select polarity. Chip select is asserted when the first word of a frame starts. It stays asserted across the words of that frame. It is released on its own once the programmed number of words has completed, or earlier when an invalidate command arrives. The chip select and the frame length are taken from the command that opens the frame. While a frame is open, the chip-select and frame-length fields of later commands are not used.

Top module: `qspi_word_engine`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `word_done`, `irq`, `sclk` and `dq_oe` are all low. Every chip select sits at its inactive level, which is the inverse of its polarity bit.
- R2: A command word is decoded as follows: chip select in bits 29:28, word length minus one in bits 25:19, operation in bits 18:16, interrupt enable in bit 14, frame length minus one in bits 11:0.
- R3: Operation 2 sends the low word-length bits of the data register, most significant bit first, on `dq_o[0]`. `dq_oe` is 4'b0001 while the word is in progress and 4'b0000 whenever the engine is idle.
- R4: Operation 1 samples `dq_i[1]` once per clock. Operation 3 samples `dq_i[1:0]` once per clock, with bit 1 the more significant. Operation 7 samples `dq_i[3:0]` once per clock. Earlier samples are more significant. The word ends up in the low bits of the data register with the upper bits cleared. `dq_oe` stays 0 during reads.
- R5: For the selected chip select, bit 0 of its configuration byte is the level `sclk` idles at. Bit 2 is the clock phase. With phase 0, data is sampled on the leading edge and launched on the trailing edge. With phase 1, data is launched on the leading edge and sampled on the trailing edge.
- R6: Bit 1 of the configuration byte gives the chip-select polarity (1 means active high). Only the chip select of the open frame is active. It stays active between words of the frame.
- R7: Chip select is released automatically when the word that completes the programmed frame length finishes.
- R8: Operation 4, when accepted, closes the open frame and releases chip select in the same cycle.
- R9: `word_done` sets when a word completes and clears when the next transfer command is accepted. `irq` equals `word_done` ANDed with the interrupt enable of the last accepted command.
- R10: A command written while `busy` is high is ignored. It starts no word, does not change the word in progress, and is not queued.
- R11: A command with operation 0, 5 or 6, or with a word length other than 8, 16 or 32, is ignored. `busy`, chip select and `word_done` all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | DW | Data register write value |
| dev_ctrl | input | 8*NUM_CS | Configuration byte for each chip select |
| dq_i | input | 4 | Serial data lines in |
| data_rdata | output | DW | Data register contents |
| busy | output | 1 | Word in progress |
| word_done | output | 1 | Word-complete flag |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| cs_o | output | NUM_CS | Chip selects, polarity per configuration byte |
| dq_o | output | 4 | Serial data lines out |
| dq_oe | output | 4 | Output enables for dq_o |

## Verification
A miscounted edge counter or a wrong sample phase shows up in the first word that completes: the captured write bits or the returned read word come out shifted or truncated. A frame counter that is off by one leaves chip select asserted, or releases it early, at the boundary of the very next frame. A busy or decode gate that lets a stray command through either restarts a word, which corrupts the data, or keeps `busy` high past the expected completion. The bench checks every one of these at the cycle each word ends.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    localparam int CS_FW   = 2;
    localparam int WL_FW   = 7;
    localparam int FL_FW   = 12;
    localparam int EDGE_W  = 8;
    localparam int DEV_W   = 8;

    localparam logic [2:0] OPC_RD1 = 3'd1;
    localparam logic [2:0] OPC_WR1 = 3'd2;
    localparam logic [2:0] OPC_RD2 = 3'd3;
    localparam logic [2:0] OPC_INV = 3'd4;
    localparam logic [2:0] OPC_RD4 = 3'd7;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2
    } lane_e;

    typedef struct packed {
        logic [CS_FW-1:0] cs;
        logic [WL_FW-1:0] wlen_m1;
        logic [2:0]       op;
        logic             ien;
        logic [FL_FW-1:0] flen_m1;
    } cmd_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } clkcfg_t;

    function automatic cmd_t cmd_decode(input logic [31:0] w);
        cmd_t r;
        r.cs      = w[29:28];
        r.wlen_m1 = w[25:19];
        r.op      = w[18:16];
        r.ien     = w[14];
        r.flen_m1 = w[11:0];
        return r;
    endfunction

    function automatic logic wlen_legal(input logic [WL_FW-1:0] m1);
        return (m1 == 7'd7) || (m1 == 7'd15) || (m1 == 7'd31);
    endfunction

    function automatic logic op_is_xfer(input logic [2:0] op);
        return (op == OPC_RD1) || (op == OPC_WR1) || (op == OPC_RD2) || (op == OPC_RD4);
    endfunction

    function automatic lane_e lanes_of(input logic [2:0] op);
        if (op == OPC_RD2) return LANE_X2;
        if (op == OPC_RD4) return LANE_X4;
        return LANE_X1;
    endfunction

    function automatic logic [1:0] lane_shift(input lane_e l);
        case (l)
            LANE_X2: return 2'd1;
            LANE_X4: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/qspi_tick.sv
module qspi_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/qspi_shift.sv
module qspi_shift
    import qspi_pkg::*;
#(
    parameter int DW       = 32,
    parameter int HALF_DIV = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WL_FW-1:0]    wlen_m1,
    input  lane_e               lanes,
    input  logic                is_wr,
    input  clkcfg_t             ccfg,
    input  logic [DW-1:0]       txd,
    input  logic [3:0]          dq_i,
    output logic                run,
    output logic                fin,
    output logic                sclk,
    output logic [DW-1:0]       rxd,
    output logic [3:0]          dq_o,
    output logic [3:0]          dq_oe
);
    logic                tick;
    logic [EDGE_W-1:0]   ecnt;
    logic [EDGE_W-1:0]   last_q;
    logic [EDGE_W-1:0]   nbits_c;
    logic [EDGE_W-1:0]   nclk_c;
    logic [DW-1:0]       tx_sh;
    logic [DW-1:0]       rx_sh;
    logic                mosi_r;
    logic                wr_q;
    logic                cpha_q;
    lane_e               lanes_q;
    logic                samp;

    qspi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    assign nbits_c = {1'b0, wlen_m1} + 8'd1;
    assign nclk_c  = nbits_c >> lane_shift(lanes);

    // even edges lead, odd edges trail; phase picks which one samples
    assign samp = (ecnt[0] == cpha_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            fin     <= 1'b0;
            sclk    <= 1'b0;
            ecnt    <= '0;
            last_q  <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            mosi_r  <= 1'b0;
            wr_q    <= 1'b0;
            cpha_q  <= 1'b0;
            lanes_q <= LANE_X1;
        end else begin
            fin <= 1'b0;
            if (start) begin
                run     <= 1'b1;
                sclk    <= ccfg.cpol;
                ecnt    <= '0;
                last_q  <= {nclk_c[EDGE_W-2:0], 1'b0} - 8'd1;
                tx_sh   <= txd << (DW - 1 - int'(wlen_m1));
                rx_sh   <= '0;
                mosi_r  <= 1'b0;
                wr_q    <= is_wr;
                cpha_q  <= ccfg.cpha;
                lanes_q <= lanes;
            end else if (run && tick) begin
                sclk <= ~sclk;
                ecnt <= ecnt + 1'b1;
                if (samp) begin
                    if (!wr_q) begin
                        case (lanes_q)
                            LANE_X2: rx_sh <= {rx_sh[DW-3:0], dq_i[1:0]};
                            LANE_X4: rx_sh <= {rx_sh[DW-5:0], dq_i};
                            default: rx_sh <= {rx_sh[DW-2:0], dq_i[1]};
                        endcase
                    end
                end else if (wr_q) begin
                    if (cpha_q) begin
                        mosi_r <= tx_sh[DW-1];
                    end
                    tx_sh <= tx_sh << 1;
                end
                if (ecnt == last_q) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign rxd   = rx_sh;
    assign dq_o  = {3'b000, (cpha_q ? mosi_r : tx_sh[DW-1])};
    assign dq_oe = (run && wr_q) ? 4'b0001 : 4'b0000;

    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run |-> (ecnt <= last_q)) else $error("edge count beyond word"); // R5

    AST_SCLK_PARK: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(sclk)) else $error("clock moved while idle"); // R5

endmodule

// File: rtl/qspi_frame.sv
module qspi_frame
    import qspi_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               open,
    input  logic               inval,
    input  logic               word_fin,
    input  logic [CS_FW-1:0]   cs_sel,
    input  logic [FL_FW-1:0]   flen_m1,
    output logic               frame_on,
    output logic [CS_FW-1:0]   cur_cs,
    output logic [NUM_CS-1:0]  cs_act
);
    logic [FL_FW-1:0] flen_q;
    logic [FL_FW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_on <= 1'b0;
            cur_cs   <= '0;
            flen_q   <= '0;
            cnt      <= '0;
        end else if (inval) begin
            frame_on <= 1'b0;
            cnt      <= '0;
        end else begin
            if (open && !frame_on) begin
                frame_on <= 1'b1;
                cur_cs   <= cs_sel;
                flen_q   <= flen_m1;
                cnt      <= '0;
            end
            if (word_fin) begin
                if (cnt == flen_q) begin
                    frame_on <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_act
        assign cs_act[i] = frame_on && (cur_cs == CS_FW'(i));
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        frame_on |-> (cnt <= flen_q)) else $error("word count past frame"); // R7

    AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_act)) else $error("more than one chip select"); // R6

endmodule

// File: rtl/qspi_word_engine.sv
module qspi_word_engine
    import qspi_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int DW       = 32,
    parameter int HALF_DIV = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_wr,
    input  logic [31:0]             cmd_word,
    input  logic                    data_wr,
    input  logic [DW-1:0]           data_wdata,
    input  logic [DEV_W*NUM_CS-1:0] dev_ctrl,
    input  logic [3:0]              dq_i,
    output logic [DW-1:0]           data_rdata,
    output logic                    busy,
    output logic                    word_done,
    output logic                    irq,
    output logic                    sclk,
    output logic [NUM_CS-1:0]       cs_o,
    output logic [3:0]              dq_o,
    output logic [3:0]              dq_oe
);
    cmd_t               c;
    logic               cs_ok;
    logic               acc_x;
    logic               acc_inv;
    logic               sh_run;
    logic               sh_fin;
    logic [DW-1:0]      sh_rxd;
    logic               frame_on;
    logic [CS_FW-1:0]   cur_cs;
    logic [CS_FW-1:0]   eff_cs;
    logic [NUM_CS-1:0]  cs_act;
    clkcfg_t            sel_cfg;
    logic [DW-1:0]      data_q;
    logic               wc_q;
    logic               ien_q;
    logic               wr_q;
    logic [NUM_CS-1:0]  spare_bits;
    logic               unused_sink;

    assign c = cmd_decode(cmd_word);

    if (NUM_CS >= 4) begin : g_cs_full
        assign cs_ok = 1'b1;
    end else begin : g_cs_part
        assign cs_ok = (int'(c.cs) < NUM_CS);
    end

    assign busy    = sh_run | sh_fin;
    assign acc_x   = cmd_wr && !busy && op_is_xfer(c.op) && wlen_legal(c.wlen_m1) && cs_ok;
    assign acc_inv = cmd_wr && !busy && (c.op == OPC_INV);
    assign eff_cs  = frame_on ? cur_cs : c.cs;

    always_comb begin
        sel_cfg = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (eff_cs == CS_FW'(i)) begin
                sel_cfg.cpol = dev_ctrl[DEV_W*i];
                sel_cfg.cpha = dev_ctrl[DEV_W*i+2];
            end
        end
    end

    qspi_shift #(.DW(DW), .HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (acc_x),
        .wlen_m1 (c.wlen_m1),
        .lanes   (lanes_of(c.op)),
        .is_wr   (c.op == OPC_WR1),
        .ccfg    (sel_cfg),
        .txd     (data_q),
        .dq_i    (dq_i),
        .run     (sh_run),
        .fin     (sh_fin),
        .sclk    (sclk),
        .rxd     (sh_rxd),
        .dq_o    (dq_o),
        .dq_oe   (dq_oe)
    );

    qspi_frame #(.NUM_CS(NUM_CS)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .open     (acc_x),
        .inval    (acc_inv),
        .word_fin (sh_fin),
        .cs_sel   (c.cs),
        .flen_m1  (c.flen_m1),
        .frame_on (frame_on),
        .cur_cs   (cur_cs),
        .cs_act   (cs_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            wc_q   <= 1'b0;
            ien_q  <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            if (sh_fin && !wr_q) begin
                data_q <= sh_rxd;
            end else if (data_wr) begin
                data_q <= data_wdata;
            end
            if (acc_x) begin
                wc_q  <= 1'b0;
                ien_q <= c.ien;
                wr_q  <= (c.op == OPC_WR1);
            end else if (sh_fin) begin
                wc_q <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_csout
        assign cs_o[i]       = cs_act[i] ? dev_ctrl[DEV_W*i+1] : ~dev_ctrl[DEV_W*i+1];
        assign spare_bits[i] = ^dev_ctrl[DEV_W*i+3 +: 5];
    end

    assign unused_sink = ^{spare_bits, cmd_word[31:30], cmd_word[27:26],
                           cmd_word[15], cmd_word[13:12]};

    assign data_rdata = data_q;
    assign word_done  = wc_q;
    assign irq        = wc_q & ien_q;

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dq_oe == 4'b0000)) else $error("driving lines while idle"); // R3

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> word_done) else $error("interrupt without completion"); // R9

    AST_FIN_FLAG: assert property (@(posedge clk) disable iff (rst)
        sh_fin |=> word_done) else $error("completion flag missing"); // R9

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_run) |-> !$past(busy)) else $error("word started while busy"); // R10

    AST_CS_STEADY: assert property (@(posedge clk) disable iff (rst)
        (frame_on && !busy && !cmd_wr) |=> $stable(cs_act)) else $error("chip select moved between words"); // R6

endmodule

// File: tb/qspi_word_engine_test.sv
module qspi_word_engine_test;
    localparam int NCS = 4;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_wr = 1'b0;
    logic [31:0]       cmd_word = '0;
    logic              data_wr = 1'b0;
    logic [DW-1:0]     data_wdata = '0;
    logic [8*NCS-1:0]  dev_ctrl = '0;
    logic [3:0]        dq_i;
    logic [DW-1:0]     data_rdata;
    logic              busy, word_done, irq, sclk;
    logic [NCS-1:0]    cs_o;
    logic [3:0]        dq_o, dq_oe;

    always #2 clk = ~clk;

    qspi_word_engine #(.NUM_CS(NCS), .DW(DW), .HALF_DIV(2)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .data_wr(data_wr), .data_wdata(data_wdata), .dev_ctrl(dev_ctrl),
        .dq_i(dq_i), .data_rdata(data_rdata), .busy(busy),
        .word_done(word_done), .irq(irq), .sclk(sclk), .cs_o(cs_o),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    // flash model state
    logic        m_cpol = 0, m_cpha = 0;
    int          m_idx = 0, m_wlen = 8, m_lanes = 1;
    logic [31:0] cap = '0, rd_pat = '0;
    logic        prev_sclk = 0, prev_busy = 0;

    // expected frame state
    bit fon = 0;
    int fcs = 0, fleft = 0;

    // current word
    int          cur_wl, cur_op, cur_ien;
    logic [31:0] cur_wdata, cur_rpat;

    function automatic logic [3:0] model_dq(int idx, int wl, int ln, logic [31:0] pat);
        int k;
        int sh;
        logic [31:0] v;
        k  = (idx < 0) ? 0 : idx;
        sh = wl - ln * (k + 1);
        if (sh < 0) return 4'b0;
        v = pat >> sh;
        if (ln == 1) return {2'b00, v[0], 1'b0};
        if (ln == 2) return {2'b00, v[1:0]};
        return v[3:0];
    endfunction

    assign dq_i = model_dq(m_idx, m_wlen, m_lanes, rd_pat);

    always @(negedge clk) begin
        if (busy && prev_busy && (sclk !== prev_sclk)) begin
            if ((sclk != m_cpol) ^ m_cpha) cap = {cap[30:0], dq_o[0]};
            else m_idx = m_idx + 1;
        end
        prev_sclk = sclk;
        prev_busy = busy;
    end

    function automatic logic [31:0] mk_cmd(int cs, int wl, int op, int ien, int flen);
        return (32'(cs) << 28) | (32'(wl - 1) << 19) | (32'(op) << 16) |
               (32'(ien) << 14) | 32'(flen - 1);
    endfunction

    function automatic logic [3:0] exp_cs();
        logic [3:0] r;
        for (int i = 0; i < NCS; i++) begin
            r[i] = (fon && fcs == i) ? dev_ctrl[8*i+1] : ~dev_ctrl[8*i+1];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy) begin
            @(negedge clk);
            n++;
            if (n > 3000) begin
                chk(0, "busy never dropped", 32'(busy), 32'd0);
                break;
            end
        end
    endtask

    task automatic start_word(int cs, int wl, int op, int ien, int flen,
                              logic [31:0] wdata, logic [31:0] rpat);
        int ecs;
        cur_wl = wl; cur_op = op; cur_ien = ien; cur_wdata = wdata; cur_rpat = rpat;
        @(negedge clk);
        if (op == 2) begin
            data_wr = 1; data_wdata = wdata;
            @(negedge clk);
            data_wr = 0;
        end
        ecs = fon ? fcs : cs;
        m_cpol = dev_ctrl[8*ecs];
        m_cpha = dev_ctrl[8*ecs+2];
        m_wlen = wl;
        m_lanes = (op == 3) ? 2 : (op == 7) ? 4 : 1;
        rd_pat = rpat;
        m_idx = m_cpha ? -1 : 0;
        cap = '0;
        cmd_wr = 1; cmd_word = mk_cmd(cs, wl, op, ien, flen);
        @(negedge clk);
        cmd_wr = 0;
        chk(busy == 1 && word_done == 0, "R9 flag clear on accept", {busy, word_done}, 32'h2);
        if (!fon) begin fon = 1; fcs = cs; fleft = flen; end
        chk(cs_o == exp_cs(), "R6 chip select during word", 32'(cs_o), 32'(exp_cs()));
        repeat (3) @(negedge clk);
        if (op == 2) chk(dq_oe == 4'b0001, "R3 output enable on write", 32'(dq_oe), 32'h1);
        else         chk(dq_oe == 4'b0000, "R4 no drive on read", 32'(dq_oe), 32'h0);
    endtask

    task automatic finish_word();
        logic [31:0] mask;
        mask = (cur_wl == 32) ? 32'hFFFF_FFFF : ((32'h1 << cur_wl) - 1);
        wait_idle();
        fleft--;
        if (fleft == 0) fon = 0;
        if (cur_op == 2) chk((cap & mask) == (cur_wdata & mask), "R3 serial write data", cap & mask, cur_wdata & mask);
        else chk(data_rdata == (cur_rpat & mask), "R4 read data", data_rdata, cur_rpat & mask);
        chk(word_done == 1, "R9 word done set", 32'(word_done), 32'h1);
        chk(irq == 1'(cur_ien), "R9 interrupt follows enable", 32'(irq), 32'(cur_ien));
        chk(cs_o == exp_cs(), "R7 chip select after word", 32'(cs_o), 32'(exp_cs()));
        chk(sclk == m_cpol, "R5 clock idle level", 32'(sclk), 32'(m_cpol));
    endtask

    task automatic do_word(int cs, int wl, int op, int ien, int flen,
                           logic [31:0] wdata, logic [31:0] rpat);
        start_word(cs, wl, op, ien, flen, wdata, rpat);
        finish_word();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        logic [3:0] cs_snap;
        seed_dummy = $urandom(32'd5150);

        // R1 reset state
        repeat (4) @(negedge clk);
        chk(busy == 0 && word_done == 0 && irq == 0, "R1 reset flags", {busy, word_done, irq}, 32'h0);
        rst = 0;
        @(negedge clk);
        chk(sclk == 0 && dq_oe == 0, "R1 reset lines", {sclk, dq_oe}, 32'h0);
        chk(cs_o == 4'hF, "R1 chip selects inactive", 32'(cs_o), 32'hF);

        // R2 R3 mode 0 single byte write
        do_word(0, 8, 2, 1, 1, 32'h0000_00A5, 32'h0);

        // R8 invalidate ends an open frame
        dev_ctrl[15:8] = 8'h02;
        do_word(1, 16, 1, 0, 4, 32'h0, 32'h0000_C3E1);
        chk(cs_o[1] == 1'b1, "R6 active-high chip select held", 32'(cs_o), 32'h2);
        @(negedge clk);
        cmd_wr = 1; cmd_word = mk_cmd(1, 8, 4, 0, 1);
        @(negedge clk);
        cmd_wr = 0;
        fon = 0;
        chk(cs_o == exp_cs(), "R8 invalidate releases chip select", 32'(cs_o), 32'(exp_cs()));
        chk(busy == 0, "R8 invalidate starts no word", 32'(busy), 32'h0);

        // R11 illegal op and word length ignored mid-frame
        dev_ctrl[23:16] = 8'h01;
        do_word(2, 32, 7, 1, 2, 32'h0, 32'h89AB_CDEF);
        cs_snap = cs_o;
        cmd_wr = 1; cmd_word = mk_cmd(2, 8, 5, 0, 1);
        @(negedge clk);
        cmd_wr = 1; cmd_word = mk_cmd(2, 12, 2, 0, 1);
        @(negedge clk);
        cmd_wr = 0;
        for (int i = 0; i < 3; i++) begin
            chk(busy == 0 && word_done == 1, "R11 ignored command", {busy, word_done}, 32'h1);
            chk(cs_o == cs_snap, "R11 chip select unchanged", 32'(cs_o), 32'(cs_snap));
            @(negedge clk);
        end
        do_word(2, 8, 3, 0, 2, 32'h0, 32'h0000_005A);

        // R10 command during busy is dropped
        dev_ctrl[31:24] = 8'h05;
        start_word(3, 32, 2, 0, 1, 32'hDEAD_BEEF, 32'h0);
        repeat (6) @(negedge clk);
        cmd_wr = 1; cmd_word = mk_cmd(0, 8, 7, 1, 3);
        @(negedge clk);
        cmd_wr = 0;
        finish_word();
        for (int i = 0; i < 4; i++) begin
            chk(busy == 0, "R10 busy command not queued", 32'(busy), 32'h0);
            @(negedge clk);
        end
        chk(cs_o == exp_cs(), "R10 no frame opened", 32'(cs_o), 32'(exp_cs()));

        // random frames covering R2 R4 R5 R6 R7
        for (int f = 0; f < 40; f++) begin
            int cs;
            int flen;
            cs = int'($urandom % 4);
            flen = 1 + int'($urandom % 3);
            @(negedge clk);
            dev_ctrl[8*cs +: 8] = 8'($urandom & 32'h7);
            for (int w = 0; w < flen; w++) begin
                int opi;
                int op;
                int wl;
                int wsel;
                opi = int'($urandom % 4);
                op = (opi == 0) ? 1 : (opi == 1) ? 2 : (opi == 2) ? 3 : 7;
                wsel = int'($urandom % 3);
                wl = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
                do_word(cs, wl, op, int'($urandom % 2), flen, $urandom, $urandom);
            end
        end

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule